// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software with a down-counter that must be refreshed inside a time window. A free-running prescaler divides the peripheral clock by a fixed base ratio and then by 1, 2, 4 or 8. The counter steps down once per prescaler period. Software refreshes the counter by writing the control register. Once the watchdog is armed, the block requests a system reset in any of three cases: the counter's top bit drops, software loads a value whose top bit is clear, or software refreshes while the counter is still above the programmed window value.

An early-warning flag is raised one step before expiry, so software can perform a last refresh or save state. The flag drives a level interrupt when its enable is set. There are three registers, each with its own write strobe and a read-data port: control, configuration and status. The reset request leaves the block as a one-cycle pulse.

Top module: `wdg_window_top`

## Requirements
- R1: After reset, ctl_rdata reads 0x7F: bit 7 is the arm bit, 0, and bits 6:0 are the counter, 0x7F. cfg_rdata reads 0x07F: bit 9 is the interrupt enable, bits 8:7 are the prescaler select and bits 6:0 are the window. sts_rdata (the early-warning flag) reads 0, and irq and rst_req are both 0.
- R2: The counter steps down by one every BASE_DIV×2^sel clock cycles, where sel is the prescaler select field with encodings 0 to 3. A control write restarts the prescaler, so the first step after the write comes a full period after the write edge.
- R3: The counter keeps stepping down while the watchdog is not armed and wraps from 0x00 to 0x7F. While the watchdog is not armed, no rst_req pulse is produced for any counter value or any write.
- R4: The arm bit is set by writing 1 to control bit 7. Writing 0 there leaves it set until reset.
- R5: When armed, the block requests a reset at the clock edge where a prescaler step takes the counter from 0x40 to 0x3F.
- R6: A control write whose counter field has bit 6 clear requests a reset. This applies when the watchdog is already armed and also when the same write arms it. The written value is still loaded.
- R7: When armed, a control write requests a reset if the counter value in the write cycle, before the write, is above the window. A write is accepted when that value is at or below the window, including when it is equal.
- R8: The early-warning flag is set when a prescaler step brings the counter to 0x40, whether or not the interrupt is enabled.
- R9: A status write with bit 0 = 0 clears the flag. A status write with bit 0 = 1 changes nothing.
- R10: irq is high exactly while the flag and the interrupt enable are both 1. The enable is set by writing 1 to configuration bit 9, and writing 0 there does not clear it.
- R11: rst_req is high for exactly one clock cycle per request. It is driven from a register, so it rises at the clock edge of the triggering write or step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | CNT_W+1 | Control write data: arm bit on top, counter below |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | CNT_W+SEL_W+1 | Configuration write data: enable, select, window |
| sts_we | input | 1 | Status register write strobe |
| sts_wdata | input | 1 | Status write data: 0 clears the flag |
| ctl_rdata | output | CNT_W+1 | Arm bit and current counter |
| cfg_rdata | output | CNT_W+SEL_W+1 | Interrupt enable, prescaler select, window |
| sts_rdata | output | 1 | Early-warning flag |
| irq | output | 1 | Early-warning interrupt level |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The embedded properties check the following on every cycle:
- the arm bit and the interrupt enable never fall;
- a reset request never appears while the watchdog is unarmed and never lasts two cycles;
- the counter holds between prescaler ticks and steps down by exactly one on a tick;
- ticks are never adjacent;
- the warning flag only rises with the counter at its threshold.

The bench scenarios are the only place where the following are shown:
- the exact step period for different select codes, and the restart of the prescaler on a refresh;
- the window comparison at its equality boundary and one above it;
- the timing of the reset pulse on a low-value load and on expiry;
- that writes of 0 to the sticky bits and writes of 1 to the flag have no effect.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   // Reason a reset request is raised in a given cycle (priority: load first)
   typedef enum logic [1:0] {
      WDG_EV_NONE   = 2'd0,
      WDG_EV_EXPIRE = 2'd1,
      WDG_EV_EARLY  = 2'd2,
      WDG_EV_LOWVAL = 2'd3
   } wdg_ev_e;

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
   parameter int BASE_DIV = 4096,
   parameter int SEL_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int MAX_SH = (1 << SEL_W) - 1;
   localparam int PCNT_W = $clog2(BASE_DIV << MAX_SH);
   localparam int LIM_W  = PCNT_W + 1;

   generate
      if (BASE_DIV < 2) begin : g_bad_base
         $error("wdg_prescaler: BASE_DIV must be at least 2");
      end
   endgenerate

   logic [PCNT_W-1:0] pcnt;
   logic [LIM_W-1:0]  limit;
   logic              at_end;

   assign limit  = LIM_W'(BASE_DIV) << sel;
   assign at_end = ({1'b0, pcnt} == (limit - LIM_W'(1)));
   assign tick   = at_end && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pcnt <= '0;
      else if (restart || at_end) pcnt <= '0;
      else                       pcnt <= pcnt + PCNT_W'(1);
   end

   // R2: a tick is always followed by at least one quiet cycle
   a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/wdg_count_core.sv
module wdg_count_core
   import wdg_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] window,
   input  logic             armed_now,
   output logic [CNT_W-1:0] cnt,
   output logic             warn_hit,
   output logic             rst_req
);
   localparam logic [CNT_W-1:0] THR  = {1'b1, {(CNT_W-1){1'b0}}};
   localparam logic [CNT_W-1:0] WARN = THR + CNT_W'(1);

   generate
      if (CNT_W < 3) begin : g_bad_width
         $error("wdg_count_core: CNT_W must be at least 3");
      end
   endgenerate

   logic    step;
   wdg_ev_e cause;

   assign step     = tick && !load;
   assign warn_hit = step && (cnt == WARN);

   always_comb begin
      cause = WDG_EV_NONE;
      if (load && !load_val[CNT_W-1]) cause = WDG_EV_LOWVAL;
      else if (load && (cnt > window)) cause = WDG_EV_EARLY;
      else if (step && (cnt == THR))   cause = WDG_EV_EXPIRE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '1;
         rst_req <= 1'b0;
      end else begin
         if (load)      cnt <= load_val;
         else if (step) cnt <= cnt - CNT_W'(1);
         rst_req <= armed_now && (cause != WDG_EV_NONE) && !rst_req;
      end
   end

   // R2: counter holds when neither a tick nor a load happens
   a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt));
   // R2: a tick without a load takes exactly one step
   a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load) |=> (cnt == $past(cnt) - CNT_W'(1)));
   // R11: requests are single-cycle
   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

endmodule

// File: rtl/wdg_warn_flag.sv
module wdg_warn_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic warn_hit,
   input  logic clr_we,
   input  logic clr_data,
   input  logic en_we,
   input  logic en_data,
   output logic flag,
   output logic irq_en,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag   <= 1'b0;
         irq_en <= 1'b0;
      end else begin
         if (warn_hit)                flag <= 1'b1;
         else if (clr_we && !clr_data) flag <= 1'b0;
         if (en_we && en_data) irq_en <= 1'b1;
      end
   end

   assign irq = flag && irq_en;

   // R10: interrupt enable never falls once set
   a_r10_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      irq_en |=> irq_en);
   // R9: flag only rises from a threshold hit
   a_r9_flag_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(warn_hit));

endmodule

// File: rtl/wdg_window_top.sv
module wdg_window_top #(
   parameter int CNT_W    = 7,
   parameter int SEL_W    = 2,
   parameter int BASE_DIV = 4096
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ctl_we,
   input  logic [CNT_W:0]         ctl_wdata,
   input  logic                   cfg_we,
   input  logic [CNT_W+SEL_W:0]   cfg_wdata,
   input  logic                   sts_we,
   input  logic                   sts_wdata,
   output logic [CNT_W:0]         ctl_rdata,
   output logic [CNT_W+SEL_W:0]   cfg_rdata,
   output logic                   sts_rdata,
   output logic                   irq,
   output logic                   rst_req
);
   localparam int ARM_BIT = CNT_W;
   localparam int SEL_LO  = CNT_W;
   localparam int IEN_BIT = CNT_W + SEL_W;
   localparam logic [CNT_W-1:0] THR = {1'b1, {(CNT_W-1){1'b0}}};

   generate
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("wdg_window_top: SEL_W must be 1 to 3");
      end
   endgenerate

   logic             armed;
   logic             armed_now;
   logic [CNT_W-1:0] window;
   logic [SEL_W-1:0] sel;
   logic [CNT_W-1:0] cnt;
   logic             tick;
   logic             warn_hit;
   logic             flag;
   logic             irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         window <= '1;
         sel    <= '0;
      end else begin
         if (ctl_we && ctl_wdata[ARM_BIT]) armed <= 1'b1;
         if (cfg_we) begin
            window <= cfg_wdata[CNT_W-1:0];
            sel    <= cfg_wdata[SEL_LO +: SEL_W];
         end
      end
   end

   assign armed_now = armed || (ctl_we && ctl_wdata[ARM_BIT]);

   wdg_prescaler #(.BASE_DIV(BASE_DIV), .SEL_W(SEL_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(ctl_we), .sel(sel), .tick(tick));

   wdg_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(ctl_we),
      .load_val(ctl_wdata[CNT_W-1:0]), .window(window), .armed_now(armed_now),
      .cnt(cnt), .warn_hit(warn_hit), .rst_req(rst_req));

   wdg_warn_flag u_flag (
      .clk(clk), .rst_n(rst_n), .warn_hit(warn_hit),
      .clr_we(sts_we), .clr_data(sts_wdata),
      .en_we(cfg_we), .en_data(cfg_wdata[IEN_BIT]),
      .flag(flag), .irq_en(irq_en), .irq(irq));

   assign ctl_rdata = {armed, cnt};
   assign cfg_rdata = {irq_en, sel, window};
   assign sts_rdata = flag;

   // R4: arm bit is sticky
   a_r4_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> armed);
   // R3: no request unless armed
   a_r3_req_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> armed);
   // R8: flag rises only with the counter at the threshold
   a_r8_flag_at_threshold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> (cnt == THR));

endmodule

// File: tb/wdg_window_top_tb.sv
module wdg_window_top_tb;
   localparam int CNT_W = 7;
   localparam int SEL_W = 2;
   localparam int BASE  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [7:0]  ctl_wdata = '0;
   logic        cfg_we = 1'b0;
   logic [9:0]  cfg_wdata = '0;
   logic        sts_we = 1'b0;
   logic        sts_wdata = 1'b0;
   logic [7:0]  ctl_rdata;
   logic [9:0]  cfg_rdata;
   logic        sts_rdata;
   logic        irq;
   logic        rst_req;

   int n_chk = 0;
   int n_bad = 0;
   int n_pulse = 0;

   always #5 clk = ~clk;

   wdg_window_top #(.CNT_W(CNT_W), .SEL_W(SEL_W), .BASE_DIV(BASE)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .sts_we(sts_we),
      .sts_wdata(sts_wdata), .ctl_rdata(ctl_rdata), .cfg_rdata(cfg_rdata),
      .sts_rdata(sts_rdata), .irq(irq), .rst_req(rst_req));

   always @(negedge clk) if (rst_req) n_pulse++;

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ctl_we = 0; cfg_we = 0; sts_we = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr_ctl(bit arm, int val);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = {arm, 7'(val)};
      @(posedge clk);
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic wr_cfg(bit ien, int sel, int win);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = {ien, 2'(sel), 7'(win)};
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wr_sts(bit v);
      @(negedge clk);
      sts_we = 1'b1; sts_wdata = v;
      @(posedge clk);
      @(negedge clk);
      sts_we = 1'b0;
   endtask

   task automatic wait_edges(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      do_reset();
      check("R1 ctl", ctl_rdata, 8'h7F);
      check("R1 cfg", cfg_rdata, 10'h07F);
      check("R1 sts", sts_rdata, 0);
      check("R1 irq", irq, 0);
      check("R1 rst_req", rst_req, 0);
   endtask

   task automatic t_rate();
      do_reset();
      wait_edges(2);
      wr_ctl(0, 8'h7F);
      wait_edges(BASE - 1);
      check("R2 full period after restart", ctl_rdata[6:0], 8'h7F);
      wait_edges(1);
      check("R2 step sel0", ctl_rdata[6:0], 8'h7E);
      wr_cfg(0, 3, 8'h7F);
      wr_ctl(0, 8'h7F);
      wait_edges(2 * BASE * 8);
      check("R2 two steps sel3", ctl_rdata[6:0], 8'h7D);
      wait_edges(BASE * 8 - 1);
      check("R2 sel3 before third step", ctl_rdata[6:0], 8'h7D);
   endtask

   task automatic t_disabled();
      int p0;
      do_reset();
      p0 = n_pulse;
      wr_ctl(0, 8'h30);
      check("R3 low load unarmed loads", ctl_rdata[6:0], 8'h30);
      wr_ctl(0, 8'h41);
      wait_edges(2 * BASE);
      check("R3 passes 0x40 unarmed", ctl_rdata[6:0], 8'h3F);
      wr_ctl(0, 8'h00);
      wait_edges(BASE);
      check("R3 wrap", ctl_rdata[6:0], 8'h7F);
      wr_cfg(0, 0, 8'h10);
      wr_ctl(0, 8'h7F);
      wait_edges(1);
      check("R3 no pulse unarmed", n_pulse - p0, 0);
   endtask

   task automatic t_arm_sticky();
      do_reset();
      wr_ctl(1, 8'h7F);
      check("R4 armed", ctl_rdata[7], 1);
      check("R7 refresh at window 0x7F accepted", rst_req, 0);
      wr_ctl(0, 8'h7F);
      check("R4 write 0 ignored", ctl_rdata[7], 1);
   endtask

   task automatic t_expiry_warn_irq();
      do_reset();
      wr_ctl(1, 8'h41);
      wait_edges(BASE);
      check("R8 at 0x40 cnt", ctl_rdata[6:0], 8'h40);
      check("R8 flag set, irq disabled", sts_rdata, 1);
      check("R5 no pulse at 0x40", rst_req, 0);
      wait_edges(BASE);
      check("R5 cnt 0x3F", ctl_rdata[6:0], 8'h3F);
      check("R5 pulse on expiry", rst_req, 1);
      wait_edges(1);
      check("R11 pulse one cycle", rst_req, 0);
      check("R10 irq gated by enable", irq, 0);
      wr_cfg(1, 0, 8'h7F);
      check("R10 irq on", irq, 1);
      wr_cfg(0, 0, 8'h7F);
      check("R10 enable sticky", cfg_rdata[9], 1);
      wr_sts(1);
      check("R9 write 1 keeps flag", sts_rdata, 1);
      wr_sts(0);
      check("R9 clear flag", sts_rdata, 0);
      check("R10 irq off after clear", irq, 0);
      wr_sts(1);
      check("R9 write 1 does not set", sts_rdata, 0);
   endtask

   task automatic t_low_value();
      do_reset();
      wr_ctl(1, 8'h30);
      check("R6 arm and low load same write", rst_req, 1);
      wait_edges(1);
      check("R11 low pulse one cycle", rst_req, 0);
      do_reset();
      wr_ctl(1, 8'h7F);
      wr_ctl(1, 8'h3F);
      check("R6 low load when armed", rst_req, 1);
      check("R6 value loaded", ctl_rdata[6:0], 8'h3F);
   endtask

   task automatic t_window();
      do_reset();
      wr_cfg(0, 3, 8'h7F);
      wr_ctl(1, 8'h45);
      wr_cfg(0, 3, 8'h45);
      wr_ctl(1, 8'h46);
      check("R7 refresh at cnt==window accepted", rst_req, 0);
      wr_ctl(1, 8'h7F);
      check("R7 refresh above window resets", rst_req, 1);
      check("R7 early value still loaded", ctl_rdata[6:0], 8'h7F);
      wait_edges(1);
      check("R11 early pulse one cycle", rst_req, 0);
   endtask

   initial begin
      t_reset_state();
      t_rate();
      t_disabled();
      t_arm_sticky();
      t_expiry_warn_irq();
      t_low_value();
      t_window();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule